// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This block is a helper for an 8-bit processor core. It handles all of the 16-bit arithmetic and address formation that the core needs. It can step a register pair up or down by one and add a register pair into the HL accumulator. It can add a signed byte to the stack pointer, build addresses in the top 256-byte page, and produce the address and the updated pointer for the post-increment and post-decrement forms of HL. It also joins two immediate bytes that arrive low byte first, and it computes relative branch targets. Each operation class has its own rule for the four flags (zero, subtract, half-carry, carry).

The sequencer presents an operation code, two 16-bit operands, one byte (an offset, an immediate, or the contents of register C) and the current flags, and raises `en_i` for one cycle. One clock edge later the unit shows the 16-bit write-back value, the 16-bit address and the new flags, and pulses `valid_o`. The unit keeps the low immediate byte internally until the matching high byte arrives. Fetch, memory access and sequencing belong to the caller.

Top module: `addr_arith_unit`

## Requirements
- R1: After reset, `result_o`, `addr_o`, `flags_o` and `valid_o` are all zero. The flag vector is packed as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C, in both `flags_i` and `flags_o`.
- R2: When `en_i` is high with a defined op code (0 to 9) at a rising edge, the outputs show that operation's results after that same edge, and `valid_o` is high for exactly that cycle.
- R3: Op 0 (increment) and op 1 (decrement) give `result_o` = `opa_i` ± 1 modulo 2^16 and `addr_o` = `result_o`, and pass `flags_i` through unchanged.
- R4: Op 2 (pair add into HL) gives `result_o` = `addr_o` = `opa_i` + `opb_i` modulo 2^16. Z is kept, N is 0, H is the carry out of bit 11 and C is the carry out of bit 15.
- R5: Op 3 (stack-pointer offset add) gives `opa_i` plus `byte_i` sign-extended to 16 bits, modulo 2^16. Z and N are 0. H is the carry out of bit 3 and C is the carry out of bit 7, both taken from the unsigned add of `opa_i[7:0]` and `byte_i`.
- R6: Op 4 (high page) gives `addr_o` = `result_o` = 0xFF00 + `byte_i` and leaves the flags unchanged.
- R7: Op 5 and op 6 (HL post-step) give `addr_o` = `opa_i`, with `result_o` = `opa_i` + 1 for op 5 and `opa_i` − 1 for op 6, modulo 2^16. Flags are unchanged.
- R8: Op 7 (relative target) gives `result_o` = `addr_o` = `opa_i` + sign-extended `byte_i`, modulo 2^16. Flags are unchanged.
- R9: Op 8 stores `byte_i` as the pending low byte and outputs {0x00, `byte_i`}. Op 9 outputs {`byte_i`, stored low byte}. The stored byte survives any other operations in between. Flags are unchanged for both.
- R10: With `en_i` low, or with op codes 10 to 15, all outputs except `valid_o` hold their values, `valid_o` is 0, and the stored low byte is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| opa_i | input | 16 | Primary 16-bit operand (pair, HL, SP or next PC) |
| opb_i | input | 16 | Second pair for the HL add |
| byte_i | input | 8 | Offset, immediate byte or register C value |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| result_o | output | 16 | Write-back value |
| addr_o | output | 16 | Formed address |
| flags_o | output | 4 | Updated flags {Z,N,H,C} |
| valid_o | output | 1 | Result strobe |

## Verification
Every result comes out of a single register stage: an operation sampled at one rising edge appears, with `valid_o`, directly after that edge. The bench drives inputs on the falling edge, lets one rising edge pass, and compares all outputs on the next falling edge before it drives anything new. Hold behaviour is checked over several idle cycles, again at falling edges. Operands sweep every offset byte against boundary values of SP and PC, every high-page byte, pair adds across carry boundaries, and paired immediates.

// File: rtl/aau_pkg.sv
package aau_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_INC     = 4'd0,
    OP_DEC     = 4'd1,
    OP_ADD_HL  = 4'd2,
    OP_ADD_SP  = 4'd3,
    OP_HIPAGE  = 4'd4,
    OP_POSTINC = 4'd5,
    OP_POSTDEC = 4'd6,
    OP_REL     = 4'd7,
    OP_IMM_LO  = 4'd8,
    OP_IMM_HI  = 4'd9
  } op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return op <= OP_IMM_HI;
  endfunction
endpackage

// File: rtl/aau_sext.sv
module aau_sext #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int EXT_W = OUT_W - IN_W;

  generate
    if (EXT_W > 0) begin : g_ext
      assign dout = {{EXT_W{din[IN_W-1]}}, din};
    end else begin : g_pass
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/aau_datapath.sv
module aau_datapath
  import aau_pkg::*;
#(
  parameter int          W           = 16,
  parameter int          BW          = 8,
  parameter logic [15:0] HIPAGE_BASE = 16'hFF00
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [BW-1:0]   byte_val,
  input  logic [BW-1:0]   lo_hold,
  output logic [W-1:0]    result,
  output logic [W-1:0]    addr
);
  localparam int PAD_W = W - BW;

  logic [W-1:0] offs_ext;
  logic [W-1:0] one;
  logic [W-1:0] plus_one;
  logic [W-1:0] minus_one;
  logic [W-1:0] offs_sum;

  aau_sext #(.IN_W(BW), .OUT_W(W)) sext_i (
    .din  (byte_val),
    .dout (offs_ext)
  );

  assign one       = {{(W-1){1'b0}}, 1'b1};
  assign plus_one  = opa + one;
  assign minus_one = opa - one;
  assign offs_sum  = opa + offs_ext;

  always_comb begin
    result = opa;
    addr   = opa;
    unique case (op_e'(op))
      OP_INC:     begin result = plus_one;  addr = plus_one;  end
      OP_DEC:     begin result = minus_one; addr = minus_one; end
      OP_ADD_HL:  begin result = opa + opb; addr = opa + opb; end
      OP_ADD_SP,
      OP_REL:     begin result = offs_sum;  addr = offs_sum;  end
      OP_HIPAGE:  begin
        result = HIPAGE_BASE[W-1:0] + {{PAD_W{1'b0}}, byte_val};
        addr   = HIPAGE_BASE[W-1:0] + {{PAD_W{1'b0}}, byte_val};
      end
      OP_POSTINC: begin result = plus_one;  addr = opa; end
      OP_POSTDEC: begin result = minus_one; addr = opa; end
      OP_IMM_LO:  begin
        result = {{PAD_W{1'b0}}, byte_val};
        addr   = {{PAD_W{1'b0}}, byte_val};
      end
      OP_IMM_HI:  begin
        result = {byte_val[PAD_W-1:0], lo_hold};
        addr   = {byte_val[PAD_W-1:0], lo_hold};
      end
      default:    begin result = opa; addr = opa; end
    endcase
  end
endmodule

// File: rtl/aau_flagpol.sv
module aau_flagpol
  import aau_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [BW-1:0]   byte_val,
  input  flags_t          fl_in,
  output flags_t          fl_out
);
  localparam int HC_W = W - 4;
  localparam int NB_W = BW / 2;

  logic [W:0]      wide_sum;
  logic [HC_W:0]   wide_half;
  logic [BW:0]     low_sum;
  logic [NB_W:0]   low_nib;

  assign wide_sum  = {1'b0, opa} + {1'b0, opb};
  assign wide_half = {1'b0, opa[HC_W-1:0]} + {1'b0, opb[HC_W-1:0]};
  assign low_sum   = {1'b0, opa[BW-1:0]} + {1'b0, byte_val};
  assign low_nib   = {1'b0, opa[NB_W-1:0]} + {1'b0, byte_val[NB_W-1:0]};

  always_comb begin
    fl_out = fl_in;
    if (op == OP_ADD_HL) begin
      fl_out.n = 1'b0;
      fl_out.h = wide_half[HC_W];
      fl_out.c = wide_sum[W];
    end else if (op == OP_ADD_SP) begin
      fl_out.z = 1'b0;
      fl_out.n = 1'b0;
      fl_out.h = low_nib[NB_W];
      fl_out.c = low_sum[BW];
    end
  end
endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
  import aau_pkg::*;
#(
  parameter int          W           = 16,
  parameter int          BW          = 8,
  parameter logic [15:0] HIPAGE_BASE = 16'hFF00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    opa_i,
  input  logic [W-1:0]    opb_i,
  input  logic [BW-1:0]   byte_i,
  input  logic [3:0]      flags_i,
  output logic [W-1:0]    result_o,
  output logic [W-1:0]    addr_o,
  output logic [3:0]      flags_o,
  output logic            valid_o
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released through a short flop chain
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  // combinational paths
  logic [W-1:0]  dp_result, dp_addr;
  logic [BW-1:0] lo_q, lo_d;
  flags_t        fl_calc;
  logic          upd;
  logic          lo_en;

  aau_datapath #(.W(W), .BW(BW), .HIPAGE_BASE(HIPAGE_BASE)) dp_i (
    .op       (op_i),
    .opa      (opa_i),
    .opb      (opb_i),
    .byte_val (byte_i),
    .lo_hold  (lo_q),
    .result   (dp_result),
    .addr     (dp_addr)
  );

  aau_flagpol #(.W(W), .BW(BW)) fp_i (
    .op       (op_i),
    .opa      (opa_i),
    .opb      (opb_i),
    .byte_val (byte_i),
    .fl_in    (flags_t'(flags_i)),
    .fl_out   (fl_calc)
  );

  // next state
  logic [W-1:0] result_d, addr_d;
  logic [3:0]   flags_d;
  logic         valid_d;

  always_comb begin
    upd      = en_i && op_defined(op_i);
    lo_en    = en_i && (op_i == OP_IMM_LO);
    lo_d     = lo_en ? byte_i : lo_q;
    result_d = upd ? dp_result : result_o;
    addr_d   = upd ? dp_addr   : addr_o;
    flags_d  = upd ? fl_calc   : flags_o;
    valid_d  = upd;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result_o <= '0;
      addr_o   <= '0;
      flags_o  <= '0;
      valid_o  <= 1'b0;
      lo_q     <= '0;
    end else begin
      result_o <= result_d;
      addr_o   <= addr_d;
      flags_o  <= flags_d;
      valid_o  <= valid_d;
      lo_q     <= lo_d;
    end
  end

  // assertions
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_defined(op_i)) |=> valid_o);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(en_i && op_defined(op_i)) |=> (!valid_o && $stable(result_o) && $stable(addr_o) && $stable(flags_o)));

  a_r3_step_flags_kept: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o == $past(flags_i)));

  a_r4_hl_add_zn: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_ADD_HL) |=> (flags_o[3] == $past(flags_i[3]) && !flags_o[2]));

  a_r5_sp_add_zn: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_ADD_SP) |=> (flags_o[3:2] == 2'b00));

  a_r6_hipage_top: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_HIPAGE) |=> (addr_o == result_o && addr_o[W-1:BW] == HIPAGE_BASE[W-1:BW]));

  a_r7_post_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_POSTINC) |=> (addr_o == $past(opa_i) && result_o == addr_o + 1'b1));

  a_r9_imm_join: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_IMM_LO) |=> (result_o[W-1:BW] == '0 && lo_q == result_o[BW-1:0]));
endmodule

// File: tb/addr_arith_unit_tb.sv
module addr_arith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [15:0] opa_i = 16'd0, opb_i = 16'd0;
  logic [7:0]  byte_i = 8'd0;
  logic [3:0]  flags_i = 4'd0;
  logic [15:0] result_o, addr_o;
  logic [3:0]  flags_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .byte_i(byte_i), .flags_i(flags_i),
    .result_o(result_o), .addr_o(addr_o), .flags_o(flags_o), .valid_o(valid_o)
  );

  logic [15:0] edges [16] = '{16'h0000, 16'h0001, 16'h0FFF, 16'h1000, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'hF000, 16'h0800, 16'h0801, 16'h8FFF, 16'h00FF,
                              16'hFF00, 16'h1234, 16'hABCD, 16'h0F0F};

  task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {v,res,addr,fl}=%h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, one rising edge, compare on the next falling edge
  task automatic run(input string req, input logic [3:0] op, input logic [15:0] a,
                     input logic [15:0] b, input logic [7:0] bv, input logic [3:0] fl,
                     input logic [15:0] er, input logic [15:0] ea, input logic [3:0] ef);
    en_i = 1'b1; op_i = op; opa_i = a; opb_i = b; byte_i = bv; flags_i = fl;
    @(posedge clk);
    @(negedge clk);
    en_i = 1'b0;
    check(req, {valid_o, result_o, addr_o, flags_o}, {1'b1, er, ea, ef});
  endtask

  function automatic logic [15:0] sx(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [3:0]  ef;
    logic [36:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", {valid_o, result_o, addr_o, flags_o}, 37'd0);

    // R3 increment / decrement with wrap
    for (int i = 0; i < 256; i++) begin
      logic [15:0] a;
      a = (i < 16) ? edges[i] : 16'(i * 16'h0101 + 16'h00F0);
      r = a + 16'd1;
      run("R3 inc", 4'd0, a, 16'h0, 8'h00, 4'(i), r, r, 4'(i));
      r = a - 16'd1;
      run("R3 dec", 4'd1, a, 16'h0, 8'h00, 4'(15 - i % 16), r, r, 4'(15 - i % 16));
    end

    // R4 pair add into HL
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        int unsigned s;
        logic [3:0] fin;
        fin = 4'((i + j) % 16);
        s = 32'(edges[i]) + 32'(edges[j]);
        ef[3] = fin[3];
        ef[2] = 1'b0;
        ef[1] = ((edges[i] & 16'h0FFF) + (edges[j] & 16'h0FFF)) > 32'h0FFF;
        ef[0] = s > 32'hFFFF;
        r = 16'(s);
        run("R4 hl add", 4'd2, edges[i], edges[j], 8'h00, fin, r, r, ef);
      end
    end

    // R5 stack pointer plus signed offset
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 256; k++) begin
        ef[3:2] = 2'b00;
        ef[1] = (32'(edges[i][3:0]) + (k % 16)) > 15;
        ef[0] = (32'(edges[i][7:0]) + k) > 255;
        r = edges[i] + sx(8'(k));
        run("R5 sp add", 4'd3, edges[i], 16'h0, 8'(k), 4'b1100, r, r, ef);
      end
    end

    // R6 high page
    for (int k = 0; k < 256; k++) begin
      r = 16'hFF00 + 16'(k);
      run("R6 hipage", 4'd4, 16'h5555, 16'h0, 8'(k), 4'(k), r, r, 4'(k));
    end

    // R7 HL post-step
    for (int i = 0; i < 16; i++) begin
      run("R7 postinc", 4'd5, edges[i], 16'h0, 8'h00, 4'hA, edges[i] + 16'd1, edges[i], 4'hA);
      run("R7 postdec", 4'd6, edges[i], 16'h0, 8'h00, 4'h5, edges[i] - 16'd1, edges[i], 4'h5);
    end

    // R8 relative target
    for (int i = 0; i < 4; i++) begin
      logic [15:0] pc;
      pc = edges[i * 4 + 2];
      for (int k = 0; k < 256; k++) begin
        r = pc + sx(8'(k));
        run("R8 rel", 4'd7, pc, 16'h0, 8'(k), 4'hF, r, r, 4'hF);
      end
    end

    // R9 little-endian immediates, low byte kept across other ops
    for (int k = 0; k < 256; k += 3) begin
      run("R9 imm lo", 4'd8, 16'h0, 16'h0, 8'(k), 4'h3, 16'(k), 16'(k), 4'h3);
      run("R9 between", 4'd0, 16'h4000, 16'h0, 8'(255 - k), 4'h3, 16'h4001, 16'h4001, 4'h3);
      r = {8'(255 - k), 8'(k)};
      run("R9 imm hi", 4'd9, 16'h0, 16'h0, 8'(255 - k), 4'h3, r, r, 4'h3);
    end

    // R10 idle and undefined codes hold outputs and stored byte
    run("R10 setup", 4'd8, 16'h0, 16'h0, 8'h5A, 4'h6, 16'h005A, 16'h005A, 4'h6);
    snap = {1'b0, result_o, addr_o, flags_o};
    en_i = 1'b0; op_i = 4'd8; byte_i = 8'hEE; opa_i = 16'h9999; flags_i = 4'h9;
    repeat (3) @(negedge clk);
    check("R10 en low", {valid_o, result_o, addr_o, flags_o}, snap);
    for (int c = 10; c < 16; c++) begin
      en_i = 1'b1; op_i = 4'(c); byte_i = 8'hC3; opa_i = 16'h7777; flags_i = 4'hF;
      @(posedge clk);
      @(negedge clk);
      en_i = 1'b0;
      check("R10 undefined op", {valid_o, result_o, addr_o, flags_o}, snap);
    end
    run("R10 byte kept", 4'd9, 16'h0, 16'h0, 8'h12, 4'h6, 16'h125A, 16'h125A, 4'h6);
    @(negedge clk);
    check("R2 valid drops", {31'd0, valid_o}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule